// File: doc/BRIEF.md
# Word-Serial Operand Shuttle for a Wide Scalar Multiplier

This block sits between a narrow 32-bit bus and a point-multiplication core whose operands are 256 bits wide. Four wide values feed the core: the scalar and the three projective coordinates of the base point. The bus writes them one word per cycle. A 2-bit selector, decoded to one-hot, picks which value a write goes to. A 3-bit word index picks the 32-bit slot inside that value. The four values stay visible to the core as full-width outputs. A rising edge on the launch input sends the core a single-cycle start pulse.

When the core signals completion, the block takes a snapshot of the three result coordinates. On the following cycles it streams them out through a separate 32-bit port, one word per cycle. The order is the X coordinate, then Y, then Z, each least significant word first, for 24 cycles in all. A go flag is high during exactly those cycles, and the port reads zero at every other time.

Because the snapshot is separate from the operand registers, the next operand set can be written and the next job launched while a result is still streaming out.

Top module: `operand_shuttle`

## Requirements
- R1: After reset, go and coreStart are low, outWord is zero, and all four operand outputs are zero.
- R2: A cycle with wrEn high writes wrWord into bits [32k+31:32k] of one operand, where k is wrIdx. The operand is chosen by wrSel: 0 the scalar (opD), 1 opX, 2 opY, 3 opZ. The new word shows from the next cycle, and every other word of every operand keeps its value.
- R3: While wrEn is low, changes on wrSel, wrIdx and wrWord leave all four operand outputs unchanged.
- R4: The first clock edge that samples act high after it was low raises coreStart for exactly one cycle, starting in the next cycle. Holding act high gives no further pulse.
- R5: A rising edge of coreDone, sampled while go is low, captures resX, resY and resZ. From the next cycle, go stays high for exactly 24 consecutive cycles.
- R6: While go is high, outWord carries one word per cycle: words 0 to 7 of the captured X, then words 0 to 7 of Y, then words 0 to 7 of Z. Word w occupies bits [32w+31:32w].
- R7: outWord is zero in every cycle where go is low.
- R8: Changes on resX, resY and resZ after the capture do not alter the words of the ongoing sequence.
- R9: A rising edge of coreDone while go is high is ignored. coreDone that stays high after a sequence ends starts no new sequence.
- R10: Operand writes and act launches during an output sequence take effect as in R2 and R4, and the sequence continues undisturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Operand word write strobe |
| wrSel | input | 2 | Operand select: 0 scalar, 1 X, 2 Y, 3 Z |
| wrIdx | input | 3 | Word slot inside the selected operand |
| wrWord | input | 32 | Write data |
| opD | output | 256 | Scalar operand to the core |
| opX | output | 256 | Base point X to the core |
| opY | output | 256 | Base point Y to the core |
| opZ | output | 256 | Base point Z to the core |
| act | input | 1 | Launch request (edge sensitive) |
| coreStart | output | 1 | One-cycle start pulse to the core |
| coreDone | input | 1 | Completion from the core (edge sensitive) |
| resX | input | 256 | Result X coordinate from the core |
| resY | input | 256 | Result Y coordinate from the core |
| resZ | input | 256 | Result Z coordinate from the core |
| go | output | 1 | High while result words are being sent |
| outWord | output | 32 | Result word stream |

## Verification
The loader is tested with random words written least significant slot first into every operand. Directed writes then hit the top and bottom slots, which catches index and select decoding faults that a full sweep would mask. Each unload uses random results, so a wrong coordinate order or word order shows up as a mismatch at a known cycle.

One unload is disturbed on purpose. Mid-stream it changes the result inputs, re-raises coreDone, writes an operand and launches act. This separates a design that snapshots its results and guards its sequence from one that reads the live core outputs or restarts.

// File: rtl/shuttle_pkg.sv
package shuttle_pkg;
  localparam int NUM_OPERANDS = 4;
  localparam int NUM_COORDS   = 3;

  typedef enum logic [1:0] {
    OPER_SCALAR = 2'd0,
    OPER_X      = 2'd1,
    OPER_Y      = 2'd2,
    OPER_Z      = 2'd3
  } oper_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // snapshot result coordinates this edge
    logic drive;     // output port carries a result word
  } shuttle_strobe_t;
endpackage

// File: rtl/shuttle_ctrl.sv
module shuttle_ctrl
  import shuttle_pkg::*;
#(
  parameter int WORDS = 8,
  localparam int IDX_W = $clog2(WORDS),
  localparam int CRD_W = $clog2(NUM_COORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act,
  input  logic             coreDone,
  output logic             coreStart,
  output logic             go,
  output logic [CRD_W-1:0] coordSel,
  output logic [IDX_W-1:0] wordSel,
  output shuttle_strobe_t  strobe
);
  localparam logic [IDX_W-1:0] LAST_WORD  = IDX_W'(WORDS - 1);
  localparam logic [CRD_W-1:0] LAST_COORD = CRD_W'(NUM_COORDS - 1);

  logic actQ, doneQ, goQ;
  logic [CRD_W-1:0] coordQ;
  logic [IDX_W-1:0] wordQ;
  logic doneRise;

  assign doneRise = coreDone && !doneQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      actQ      <= 1'b0;
      doneQ     <= 1'b0;
      coreStart <= 1'b0;
    end else begin
      actQ      <= act;
      doneQ     <= coreDone;
      coreStart <= act && !actQ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      goQ    <= 1'b0;
      coordQ <= '0;
      wordQ  <= '0;
    end else if (!goQ) begin
      if (doneRise) begin
        goQ    <= 1'b1;
        coordQ <= '0;
        wordQ  <= '0;
      end
    end else if (wordQ == LAST_WORD) begin
      wordQ <= '0;
      if (coordQ == LAST_COORD) begin
        goQ    <= 1'b0;
        coordQ <= '0;
      end else begin
        coordQ <= coordQ + 1'b1;
      end
    end else begin
      wordQ <= wordQ + 1'b1;
    end
  end

  always_comb begin
    strobe.capture = doneRise && !goQ;
    strobe.drive   = goQ;
  end

  assign go       = goQ;
  assign coordSel = coordQ;
  assign wordSel  = wordQ;
endmodule

// File: rtl/shuttle_datapath.sv
module shuttle_datapath
  import shuttle_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int VAL_W  = 256,
  localparam int WORDS = VAL_W / WORD_W,
  localparam int IDX_W = $clog2(WORDS),
  localparam int CRD_W = $clog2(NUM_COORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [WORD_W-1:0] wrWord,
  output logic [VAL_W-1:0]  opD,
  output logic [VAL_W-1:0]  opX,
  output logic [VAL_W-1:0]  opY,
  output logic [VAL_W-1:0]  opZ,
  input  logic [VAL_W-1:0]  resX,
  input  logic [VAL_W-1:0]  resY,
  input  logic [VAL_W-1:0]  resZ,
  input  shuttle_strobe_t   strobe,
  input  logic [CRD_W-1:0]  coordSel,
  input  logic [IDX_W-1:0]  wordSel,
  output logic [WORD_W-1:0] outWord
);
  logic [NUM_OPERANDS-1:0] selHot;
  logic [VAL_W-1:0] bank [NUM_OPERANDS];
  logic [VAL_W-1:0] resIn [NUM_COORDS];
  logic [VAL_W-1:0] resCap [NUM_COORDS];

  always_comb begin
    selHot        = '0;
    selHot[wrSel] = 1'b1;
  end

  for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank[g] <= '0;
      else if (wrEn && selHot[g]) bank[g][wrIdx*WORD_W +: WORD_W] <= wrWord;
    end
  end

  assign opD = bank[OPER_SCALAR];
  assign opX = bank[OPER_X];
  assign opY = bank[OPER_Y];
  assign opZ = bank[OPER_Z];

  assign resIn[0] = resX;
  assign resIn[1] = resY;
  assign resIn[2] = resZ;

  for (genvar c = 0; c < NUM_COORDS; c++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) resCap[c] <= '0;
      else if (strobe.capture) resCap[c] <= resIn[c];
    end
  end

  always_comb begin
    outWord = '0;
    if (strobe.drive) outWord = resCap[coordSel][wordSel*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/operand_shuttle.sv
module operand_shuttle
  import shuttle_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int VAL_W  = 256,
  localparam int WORDS = VAL_W / WORD_W,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [WORD_W-1:0] wrWord,
  output logic [VAL_W-1:0]  opD,
  output logic [VAL_W-1:0]  opX,
  output logic [VAL_W-1:0]  opY,
  output logic [VAL_W-1:0]  opZ,
  input  logic              act,
  output logic              coreStart,
  input  logic              coreDone,
  input  logic [VAL_W-1:0]  resX,
  input  logic [VAL_W-1:0]  resY,
  input  logic [VAL_W-1:0]  resZ,
  output logic              go,
  output logic [WORD_W-1:0] outWord
);
  localparam int CRD_W = $clog2(NUM_COORDS);

  shuttle_strobe_t  strobe;
  logic [CRD_W-1:0] coordSel;
  logic [IDX_W-1:0] wordSel;

  shuttle_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .act(act), .coreDone(coreDone),
    .coreStart(coreStart), .go(go), .coordSel(coordSel),
    .wordSel(wordSel), .strobe(strobe)
  );

  shuttle_datapath #(.WORD_W(WORD_W), .VAL_W(VAL_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrIdx(wrIdx),
    .wrWord(wrWord), .opD(opD), .opX(opX), .opY(opY), .opZ(opZ),
    .resX(resX), .resY(resY), .resZ(resZ), .strobe(strobe),
    .coordSel(coordSel), .wordSel(wordSel), .outWord(outWord)
  );
endmodule

// File: rtl/shuttle_checker.sv
module shuttle_checker #(
  parameter int WORD_W = 32,
  parameter int VAL_W  = 256,
  localparam int TOTAL = 3 * (VAL_W / WORD_W),
  localparam int RUN_W = $clog2(TOTAL + 1) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrEn,
  input logic [VAL_W-1:0]  opD,
  input logic [VAL_W-1:0]  opX,
  input logic [VAL_W-1:0]  opY,
  input logic [VAL_W-1:0]  opZ,
  input logic              act,
  input logic              coreStart,
  input logic              coreDone,
  input logic              go,
  input logic [WORD_W-1:0] outWord
);
  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) runLen <= '0;
    else if (go) runLen <= runLen + 1'b1;
    else runLen <= '0;
  end

  a_r3_ops_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |=> ($stable(opD) && $stable(opX) && $stable(opY) && $stable(opZ)));

  a_r4_start_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act) |=> coreStart);

  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    coreStart |=> !coreStart);

  a_r5_go_begins: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(coreDone) && !go) |=> go);

  a_r5_go_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (runLen < RUN_W'(TOTAL)));

  a_r5_go_full_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(go) |-> (runLen == RUN_W'(TOTAL)));

  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !go |-> (outWord == '0));
endmodule

bind operand_shuttle shuttle_checker #(.WORD_W(WORD_W), .VAL_W(VAL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .opD(opD), .opX(opX), .opY(opY),
  .opZ(opZ), .act(act), .coreStart(coreStart), .coreDone(coreDone),
  .go(go), .outWord(outWord)
);

// File: tb/operand_shuttle_bench.sv
module operand_shuttle_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic wrEn;
  logic [1:0] wrSel;
  logic [2:0] wrIdx;
  logic [31:0] wrWord;
  logic [255:0] opD, opX, opY, opZ;
  logic act, coreStart, coreDone;
  logic [255:0] resX, resY, resZ;
  logic go;
  logic [31:0] outWord;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;
  logic [255:0] modelOp [4];
  logic [255:0] expRes [3];

  always #4 clk = ~clk;

  operand_shuttle u_operand_shuttle (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrIdx(wrIdx),
    .wrWord(wrWord), .opD(opD), .opX(opX), .opY(opY), .opZ(opZ),
    .act(act), .coreStart(coreStart), .coreDone(coreDone),
    .resX(resX), .resY(resY), .resZ(resZ), .go(go), .outWord(outWord)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [255:0] actual, input logic [255:0] expected);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, actual, expected);
    end
  endtask

  function automatic logic [255:0] rand256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [255:0] opOut(input int s);
    case (s)
      0: return opD;
      1: return opX;
      2: return opY;
      default: return opZ;
    endcase
  endfunction

  task automatic checkOps(input string req);
    for (int s = 0; s < 4; s++)
      chk(opOut(s) == modelOp[s], req, opOut(s), modelOp[s]);
  endtask

  // inputs change at negedge; one posedge later the write is visible
  task automatic writeWord(input int s, input int k, input logic [31:0] w);
    wrEn = 1'b1; wrSel = 2'(s); wrIdx = 3'(k); wrWord = w;
    modelOp[s][k*32 +: 32] = w;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runUnload(input bit disturb);
    logic [31:0] w;
    expRes[0] = rand256(); expRes[1] = rand256(); expRes[2] = rand256();
    resX = expRes[0]; resY = expRes[1]; resZ = expRes[2];
    chk(outWord == 32'd0 && !go, "R7 idle before unload", {224'd0, outWord}, 256'd0);
    coreDone = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 24; k++) begin
      w = expRes[k/8][(k%8)*32 +: 32];
      chk(go == 1'b1, "R5 go high in sequence", {255'd0, go}, 256'd1);
      chk(outWord == w, "R6 word order", {224'd0, outWord}, {224'd0, w});
      if (disturb) begin
        if (k == 3) begin resX = rand256(); resY = rand256(); resZ = rand256(); end // R8
        if (k == 5) coreDone = 1'b0;
        if (k == 9) coreDone = 1'b1;   // R9 ignored rise
        if (k == 13) begin
          chk(opY == modelOp[2], "R10 write during unload", opY, modelOp[2]);
          act = 1'b1;
        end
        if (k == 14) begin
          chk(coreStart == 1'b1, "R10 launch during unload", {255'd0, coreStart}, 256'd1);
          act = 1'b0;
        end
        if (k == 12) begin
          wrEn = 1'b1; wrSel = 2'd2; wrIdx = 3'd4; wrWord = $urandom;
          modelOp[2][4*32 +: 32] = wrWord;
        end else begin
          wrEn = 1'b0;
        end
      end
      @(negedge clk);
    end
    chk(go == 1'b0, "R5 go falls after 24 words", {255'd0, go}, 256'd0);
    chk(outWord == 32'd0, "R7 zero after sequence", {224'd0, outWord}, 256'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(go == 1'b0, "R9 held done no restart", {255'd0, go}, 256'd0);
    end
    coreDone = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wrEn = 0; wrSel = 0; wrIdx = 0; wrWord = 0;
    act = 0; coreDone = 0; resX = 0; resY = 0; resZ = 0;
    for (int s = 0; s < 4; s++) modelOp[s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(go == 1'b0, "R1 go", {255'd0, go}, 256'd0);
    chk(coreStart == 1'b0, "R1 coreStart", {255'd0, coreStart}, 256'd0);
    chk(outWord == 32'd0, "R1 outWord", {224'd0, outWord}, 256'd0);
    checkOps("R1 operands zero");

    // R2 random load, least significant word first
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 8; k++) writeWord(s, k, $urandom);
      checkOps("R2 full operand load");
    end
    // R2 directed slot boundaries
    writeWord(1, 7, 32'hFFFF_FFFF);
    checkOps("R2 top slot of X");
    writeWord(3, 0, 32'h0000_0001);
    checkOps("R2 bottom slot of Z");
    writeWord(0, 3, 32'hA5A5_5A5A);
    checkOps("R2 middle slot of scalar");

    // R3 bus activity without strobe
    for (int k = 0; k < 6; k++) begin
      wrSel = 2'($urandom); wrIdx = 3'($urandom); wrWord = $urandom;
      @(negedge clk);
    end
    checkOps("R3 no write without wrEn");

    // R4 launch pulse
    act = 1'b1;
    @(negedge clk);
    chk(coreStart == 1'b1, "R4 pulse after rise", {255'd0, coreStart}, 256'd1);
    @(negedge clk);
    chk(coreStart == 1'b0, "R4 pulse single cycle", {255'd0, coreStart}, 256'd0);
    @(negedge clk);
    chk(coreStart == 1'b0, "R4 held act no repeat", {255'd0, coreStart}, 256'd0);
    act = 1'b0;
    @(negedge clk);

    // R5 R6 R7 plain unloads, then disturbed unload for R8 R9 R10
    runUnload(1'b0);
    runUnload(1'b0);
    runUnload(1'b1);
    checkOps("R10 operands after disturbed unload");

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule